// File: doc/BRIEF.md
# Fault Address Capture Register Bank

This block keeps the fault record for a processor's load/store unit. When the load/store path reports a fault, it gives the address the instruction asked for, the address of the aligned piece that actually faulted, and the fault class. A protection-class fault stores the actual faulting address. A bus-class fault stores the originally requested address. Each stored address has a valid flag in a shared status word. A stored address cannot be overwritten until software writes 1 to its flag, which clears the flag and lets the register capture again.

Next to the two address registers sits a 32-bit auxiliary status word. A one-cycle pulse on any of its input lines sets the matching bit. Software clears bits by writing 1 to them. The block drives no exception or interrupt request.

Software reaches the bank over a small register bus with byte enables. The status word may be accessed as a byte, an aligned halfword or a word. Every other word accepts only full aligned words. An access outside these rules gets an error response, reads zero and changes nothing.

Top module: `fault_capture_bank`

## Requirements
- R1: After reset, all four registers read zero, and both valid flags are 0.
- R2: A fault report with class 0 (protection) loads the actual faulting address into the protection address word (offset 0x4) and sets status bit 0.
- R3: A fault report with class 1 (bus) loads the requested address into the bus address word (offset 0x8) and sets status bit 8.
- R4: While a class's valid flag is 1, a further fault of that class leaves its address word unchanged.
- R5: A legal write with 1 in status bit 0 or bit 8 clears that flag. A fault of the same class arriving in the same cycle is captured anyway, so the flag stays 1 and the address word takes the new value.
- R6: A one-cycle high pulse on aux_fault[i] sets bit i of the auxiliary word (offset 0xC), and the bit stays set. The block has no exception or interrupt output.
- R7: Writing to the auxiliary word clears the bits written as 1 and leaves the bits written as 0. When a pulse and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: An access to the status word (offset 0x0) is legal when its byte enables are 0001, 0010, 0100, 1000, 0011, 1100 or 1111. Every other word is legal only with 1111. In every case addr[1:0] must be 00.
- R9: An illegal access returns rsp_err=1 and rdata=0, and a write that is illegal changes no register.
- R10: The two address words are read-only. A legal write to them has no effect.
- R11: Every request is answered exactly one cycle later with rsp_vld=1. Read data carries only the enabled byte lanes, and the other lanes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_vld | input | 1 | Fault report strobe |
| flt_class | input | 1 | Fault class: 0 protection, 1 bus |
| flt_req_addr | input | 32 | Address requested by the instruction |
| flt_act_addr | input | 32 | Address of the aligned access that faulted |
| aux_fault | input | 32 | Auxiliary fault pulse lines |
| req | input | 1 | Register bus request |
| we | input | 1 | Write when 1, read when 0 |
| addr | input | 4 | Byte address within the bank |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after req |
| rsp_err | output | 1 | Access rejected |
| rdata | output | 32 | Read data |

## Verification
Two pairs of functions can land in the same cycle. In the first, a clear-by-write to the auxiliary word coincides with an auxiliary pulse on a bit it clears. In the second, a write-1 to a valid flag coincides with a new fault of that class. The bench drives both in the same negative-edge slot so they share one capturing edge. It then reads back to confirm that the pulsed bit survived while the other bits cleared, and that the flag stayed set with the new address loaded. Access legality is swept exhaustively over word offset, low address bits and byte-enable pattern. Each error flag and each masked read value is compared against an arithmetic model.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AUX_W  = 32;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned NLANE  = DATA_W / 8;

  typedef enum logic [1:0] {
    W_STATUS = 2'd0,
    W_PADDR  = 2'd1,
    W_BADDR  = 2'd2,
    W_AUX    = 2'd3
  } word_sel_e;

  typedef enum logic {
    FLT_PROT = 1'b0,
    FLT_BUS  = 1'b1
  } flt_class_e;

  localparam int unsigned PVLD_BIT = 0;
  localparam int unsigned BVLD_BIT = 8;
endpackage

// File: rtl/fcb_addr_capture.sv
module fcb_addr_capture #(
  parameter int unsigned AW      = 32,
  parameter bit          USE_REQ = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] act_addr,
  output logic          valid,
  output logic [AW-1:0] addr
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          load;

  generate
    if (USE_REQ) begin : g_req
      assign addr_d = req_addr;
    end else begin : g_act
      assign addr_d = act_addr;
    end
  endgenerate

  always_comb begin
    load    = hit && (!valid_q || clr);
    valid_d = valid_q;
    if (hit)      valid_d = 1'b1;
    else if (clr) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) addr_q <= addr_d;
    end
  end

  assign valid = valid_q;
  assign addr  = addr_q;

  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> $stable(addr_q));
  p_hit_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> valid_q);
endmodule

// File: rtl/fcb_aux_status.sv
module fcb_aux_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;
  logic         upd;

  always_comb begin
    q_d = (q_q & ~clr_mask) | set_in;
    upd = (|set_in) || (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q = q_q;

  p_aux_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in != '0) |=> ((q_q & $past(set_in)) == $past(set_in)));
  p_aux_no_spont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((q_q & ~$past(q_q) & ~$past(set_in)) == '0));
endmodule

// File: rtl/fcb_regbus.sv
module fcb_regbus
  import fcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [OFF_W-1:0]  addr,
  input  logic [NLANE-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pvalid,
  input  logic              bvalid,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] baddr,
  input  logic [AUX_W-1:0]  aux_q,
  output logic              clr_p,
  output logic              clr_b,
  output logic [AUX_W-1:0]  aux_clr,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rdata
);
  word_sel_e         sel;
  logic              aligned, lanes_ok, legal, wr_ok;
  logic [DATA_W-1:0] word, lane_mask, rdata_d;
  logic              vld_q, err_q, err_d;
  logic [DATA_W-1:0] rdata_q;

  assign sel     = word_sel_e'(addr[OFF_W-1:2]);
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    lanes_ok = (be == 4'b1111);
    if (sel == W_STATUS) begin
      case (be)
        4'b0001, 4'b0010, 4'b0100, 4'b1000,
        4'b0011, 4'b1100: lanes_ok = 1'b1;
        default: ;
      endcase
    end
  end

  assign legal = aligned && lanes_ok;
  assign wr_ok = req && we && legal;

  generate
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      assign lane_mask[8*i +: 8] = {8{be[i]}};
    end
  endgenerate

  always_comb begin
    word = '0;
    case (sel)
      W_STATUS: begin
        word[PVLD_BIT] = pvalid;
        word[BVLD_BIT] = bvalid;
      end
      W_PADDR: word = paddr;
      W_BADDR: word = baddr;
      W_AUX:   word = aux_q;
      default: word = '0;
    endcase
  end

  always_comb begin
    rdata_d = '0;
    if (req && !we && legal) rdata_d = word & lane_mask;
    err_d   = req && !legal;
    clr_p   = wr_ok && (sel == W_STATUS) && be[PVLD_BIT/8] && wdata[PVLD_BIT];
    clr_b   = wr_ok && (sel == W_STATUS) && be[BVLD_BIT/8] && wdata[BVLD_BIT];
    aux_clr = (wr_ok && (sel == W_AUX)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      vld_q   <= req;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_vld = vld_q;
  assign rsp_err = err_q;
  assign rdata   = rdata_q;

  p_err_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rdata == '0));
  p_rsp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_vld);
  p_err_has_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_vld);
endmodule

// File: rtl/fault_capture_bank.sv
module fault_capture_bank
  import fcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_vld,
  input  logic              flt_class,
  input  logic [ADDR_W-1:0] flt_req_addr,
  input  logic [ADDR_W-1:0] flt_act_addr,
  input  logic [AUX_W-1:0]  aux_fault,
  input  logic              req,
  input  logic              we,
  input  logic [OFF_W-1:0]  addr,
  input  logic [NLANE-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              hit_p, hit_b, clr_p, clr_b;
  logic              pvalid, bvalid;
  logic [ADDR_W-1:0] paddr, baddr;
  logic [AUX_W-1:0]  aux_q, aux_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign hit_p = flt_vld && (flt_class_e'(flt_class) == FLT_PROT);
  assign hit_b = flt_vld && (flt_class_e'(flt_class) == FLT_BUS);

  fcb_addr_capture #(.AW(ADDR_W), .USE_REQ(1'b0)) u_prot (
    .clk(clk), .rst_n(rst_int_n), .hit(hit_p), .clr(clr_p),
    .req_addr(flt_req_addr), .act_addr(flt_act_addr),
    .valid(pvalid), .addr(paddr)
  );

  fcb_addr_capture #(.AW(ADDR_W), .USE_REQ(1'b1)) u_bus (
    .clk(clk), .rst_n(rst_int_n), .hit(hit_b), .clr(clr_b),
    .req_addr(flt_req_addr), .act_addr(flt_act_addr),
    .valid(bvalid), .addr(baddr)
  );

  fcb_aux_status #(.W(AUX_W)) u_aux (
    .clk(clk), .rst_n(rst_int_n), .set_in(aux_fault),
    .clr_mask(aux_clr), .q(aux_q)
  );

  fcb_regbus u_bus_if (
    .clk(clk), .rst_n(rst_int_n), .req(req), .we(we), .addr(addr),
    .be(be), .wdata(wdata), .pvalid(pvalid), .bvalid(bvalid),
    .paddr(paddr), .baddr(baddr), .aux_q(aux_q),
    .clr_p(clr_p), .clr_b(clr_b), .aux_clr(aux_clr),
    .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rdata(rdata)
  );

  p_capture_class_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hit_b && !bvalid) |=> (baddr == $past(flt_req_addr)));
  p_capture_act_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hit_p && !pvalid) |=> (paddr == $past(flt_act_addr)));
endmodule

// File: tb/sim_fault_capture_bank.sv
module sim_fault_capture_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_vld = 1'b0, flt_class = 1'b0;
  logic [31:0] flt_req_addr = '0, flt_act_addr = '0, aux_fault = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0, be = '0;
  logic [31:0] wdata = '0;
  logic        rsp_vld, rsp_err;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  logic [31:0] got_d;
  logic        got_e, got_v;
  logic [31:0] pend_aux = '0;
  logic        pend_flt = 1'b0, pend_cls = 1'b0;
  logic [31:0] pend_req = '0, pend_act = '0;

  // model
  logic        m_pv = 0, m_bv = 0;
  logic [31:0] m_pa = '0, m_ba = '0, m_aux = '0;

  always #4 clk = ~clk;

  fault_capture_bank u0 (
    .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .flt_class(flt_class),
    .flt_req_addr(flt_req_addr), .flt_act_addr(flt_act_addr),
    .aux_fault(aux_fault), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rdata(rdata)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // one cycle: optional bus request plus pending fault/aux stimulus
  task automatic cyc(input logic rq, input logic w, input logic [3:0] a,
                     input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = rq; we = w; addr = a; be = b; wdata = d;
    aux_fault = pend_aux; flt_vld = pend_flt; flt_class = pend_cls;
    flt_req_addr = pend_req; flt_act_addr = pend_act;
    @(posedge clk);
    @(negedge clk);
    got_v = rsp_vld; got_e = rsp_err; got_d = rdata;
    req = 0; we = 0; aux_fault = '0; flt_vld = 0;
    pend_aux = '0; pend_flt = 0;
  endtask

  task automatic fault(input logic cls, input logic [31:0] ra, input logic [31:0] aa);
    pend_flt = 1; pend_cls = cls; pend_req = ra; pend_act = aa;
    cyc(0, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] mword(input int off);
    case (off)
      0: return {23'd0, m_bv, 7'd0, m_pv};
      1: return m_pa;
      2: return m_ba;
      default: return m_aux;
    endcase
  endfunction

  function automatic logic lanes_legal(input int off, input logic [3:0] b);
    if (b == 4'hF) return 1'b1;
    if (off != 0) return 1'b0;
    return (b == 4'h1 || b == 4'h2 || b == 4'h4 || b == 4'h8 || b == 4'h3 || b == 4'hC);
  endfunction

  function automatic logic [31:0] bmask(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic rd_word(input string r, input int off);
    cyc(1, 0, 4'(off * 4), 4'hF, 0);
    chk(r, got_d, mword(off));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int o = 0; o < 4; o++) rd_word("R1", o);
    chk("R1 err", {31'd0, got_e}, 0);

    // R2 protection fault: actual address kept
    fault(0, 32'h1000_0002, 32'h1000_0004);
    m_pv = 1; m_pa = 32'h1000_0004;
    rd_word("R2 status", 0); rd_word("R2 addr", 1);
    // R3 bus fault: requested address kept
    fault(1, 32'h2000_0003, 32'h2000_0004);
    m_bv = 1; m_ba = 32'h2000_0003;
    rd_word("R3 status", 0); rd_word("R3 addr", 2);
    // R4 no overwrite while valid
    fault(0, 32'h3000_0001, 32'h3000_0000);
    fault(1, 32'h4000_0001, 32'h4000_0000);
    rd_word("R4 paddr", 1); rd_word("R4 baddr", 2);

    // R6 each aux line sets its bit and accumulates
    for (int i = 0; i < 32; i++) begin
      pend_aux = 32'd1 << i;
      cyc(0, 0, 0, 0, 0);
      m_aux[i] = 1'b1;
      rd_word("R6", 3);
    end

    // R8/R9/R11 exhaustive legality sweep (reads)
    for (int o = 0; o < 4; o++)
      for (int lo = 0; lo < 4; lo++)
        for (int b = 0; b < 16; b++) begin
          logic ok;
          ok = (lo == 0) && lanes_legal(o, 4'(b));
          cyc(1, 0, 4'(o * 4 + lo), 4'(b), 0);
          chk("R11 vld", {31'd0, got_v}, 1);
          chk("R8 err", {31'd0, got_e}, {31'd0, !ok});
          chk("R9 rdata", got_d, ok ? (mword(o) & bmask(4'(b))) : 32'd0);
        end

    // R9 illegal writes of all ones change nothing
    for (int o = 0; o < 4; o += 3)
      for (int lo = 0; lo < 4; lo++)
        for (int b = 0; b < 16; b++)
          if (!((lo == 0) && lanes_legal(o, 4'(b)))) begin
            cyc(1, 1, 4'(o * 4 + lo), 4'(b), 32'hFFFF_FFFF);
            chk("R9 werr", {31'd0, got_e}, 1);
          end
    rd_word("R9 status", 0); rd_word("R9 aux", 3);

    // R10 address words read-only
    cyc(1, 1, 4'h4, 4'hF, 32'h0);
    cyc(1, 1, 4'h8, 4'hF, 32'h0);
    chk("R10 err", {31'd0, got_e}, 0);
    rd_word("R10 paddr", 1); rd_word("R10 baddr", 2);

    // R7 write-1-to-clear, zeros leave bits
    cyc(1, 1, 4'hC, 4'hF, 32'h0000_FFFF);
    m_aux = 32'hFFFF_0000;
    rd_word("R7 w1c", 3);
    cyc(1, 1, 4'hC, 4'hF, 32'h0);
    rd_word("R7 w0", 3);
    // R7 set wins over simultaneous clear
    pend_aux = 32'h0000_0020;
    cyc(1, 1, 4'hC, 4'hF, 32'hFFFF_FFFF);
    m_aux = 32'h0000_0020;
    rd_word("R7 same cycle", 3);

    // R5/R8 byte write to lane 1 clears bus valid only
    cyc(1, 1, 4'h0, 4'h2, 32'h0000_0100);
    chk("R8 byte wr err", {31'd0, got_e}, 0);
    m_bv = 0;
    rd_word("R5 bus clr", 0);
    fault(1, 32'h5000_0001, 32'h5000_0000);
    m_bv = 1; m_ba = 32'h5000_0001;
    rd_word("R5 rearm", 2); rd_word("R5 status", 0);
    // R5 clear and same-class fault together: capture wins
    pend_flt = 1; pend_cls = 0; pend_req = 32'h6000_0002; pend_act = 32'h6000_0000;
    cyc(1, 1, 4'h0, 4'hF, 32'h0000_0001);
    m_pa = 32'h6000_0000;
    rd_word("R5 clr+flt status", 0); rd_word("R5 clr+flt addr", 1);
    // R5 clearing both flags
    cyc(1, 1, 4'h0, 4'h3, 32'h0000_0101);
    m_pv = 0; m_bv = 0;
    rd_word("R5 both clr", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule